// File: doc/BRIEF.md
# Bit-Field and Leading-Count Unit

A single-cycle, purely combinational datapath for a 32-bit integer pipeline. It handles seven bit-manipulation operations on its two register operands. It counts leading zeros or leading ones and extracts or inserts a bit field. It also swaps the bytes inside each halfword and sign-extends a byte or a halfword. The execute stage feeds it the instruction's function code, a group bit and the two 5-bit geometry fields from the instruction word, together with the two operand values. The result comes back in the same cycle.

The operation is chosen by the function code within its instruction group. The group bit is 0 for the multiply/count group and 1 for the bit-field group. In the byte-shuffle sub-group, the low geometry field (the shift-amount slot of the instruction) picks the operation. An encoding that the unit does not recognise raises the invalid flag, and so does an impossible field geometry. In both cases the result is forced to zero, so the pipeline can turn the flag into a reserved-instruction exception.

Top module: `bmu_core`

## Requirements
- R1: With group 0 and function 0x20, the result is the number of consecutive zero bits of `rs_i` counted from bit 31 downward, stopping at the first one; an all-zero operand gives 32.
- R2: With group 0 and function 0x21, the result is the number of consecutive one bits of `rs_i` counted from bit 31 downward, stopping at the first zero; an all-ones operand gives 32.
- R3: With group 1 and function 0x00 (extract), and with `fhi_i` + `flo_i` <= 31, the result is `rs_i` bits [`fhi_i`+`flo_i` : `flo_i`], right-justified and zero-extended; `fhi_i` holds the field size minus one.
- R4: An extract with `fhi_i` + `flo_i` > 31 sets `bad_o` and drives the result to zero.
- R5: With group 1 and function 0x04 (insert), and with `flo_i` <= `fhi_i`, the result equals `rt_i` except in bits [`fhi_i` : `flo_i`], which hold `rs_i` bits [`fhi_i`-`flo_i` : 0].
- R6: An insert with `flo_i` > `fhi_i` sets `bad_o` and drives the result to zero.
- R7: With group 1, function 0x20 and `flo_i` = 0x02, each 16-bit half of `rt_i` has its two bytes exchanged.
- R8: With group 1, function 0x20 and `flo_i` = 0x10, the result is `rt_i` bits [7:0] with bit 7 copied into bits 31..8.
- R9: With group 1, function 0x20 and `flo_i` = 0x18, the result is `rt_i` bits [15:0] with bit 15 copied into bits 31..16.
- R10: Any other combination of group, function code and (for the shuffle sub-group) `flo_i` sets `bad_o` and gives a zero result; every recognised operation with legal geometry clears `bad_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| grp_i | input | 1 | Instruction group: 0 = multiply/count group, 1 = bit-field group |
| fn_i | input | 6 | Function code of the instruction |
| fhi_i | input | 5 | Upper geometry field (field size minus one for extract, top bit for insert) |
| flo_i | input | 5 | Lower geometry field (field start bit, or shuffle selector) |
| rs_i | input | 32 | First register operand |
| rt_i | input | 32 | Second register operand |
| res_o | output | 32 | Operation result |
| bad_o | output | 1 | Unrecognised encoding or illegal field geometry |

## Verification
An encoding error and a geometry error can both apply in the same cycle. One case is an extract or insert encoding with an illegal field. Another is the shuffle function code with a low field that selects nothing, where `flo_i` is both geometry and selector. The bench draws the geometry fields uniformly over their full range on every extract and insert, so the illegal half of the space gets plenty of hits. It also mixes in arbitrary group/function/selector values. Each case is judged on the one expected outcome: the flag raised and the result zero, whichever cause applies.

// File: rtl/bmu_pkg.sv
package bmu_pkg;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_CLZ  = 3'd1,
    OP_CLO  = 3'd2,
    OP_EXT  = 3'd3,
    OP_INS  = 3'd4,
    OP_WSBH = 3'd5,
    OP_SEB  = 3'd6,
    OP_SEH  = 3'd7
  } bmu_op_e;

  localparam logic [5:0] FN_CLZ  = 6'h20;
  localparam logic [5:0] FN_CLO  = 6'h21;
  localparam logic [5:0] FN_EXT  = 6'h00;
  localparam logic [5:0] FN_INS  = 6'h04;
  localparam logic [5:0] FN_SHUF = 6'h20;

  localparam logic [4:0] SH_WSBH = 5'h02;
  localparam logic [4:0] SH_SEB  = 5'h10;
  localparam logic [4:0] SH_SEH  = 5'h18;

endpackage

// File: rtl/bmu_decode.sv
module bmu_decode
  import bmu_pkg::*;
(
  input  logic       grp_i,
  input  logic [5:0] fn_i,
  input  logic [4:0] sel_i,
  output bmu_op_e    op_o
);

  localparam int NOPS = 7;

  logic [NOPS-1:0] hit;

  always_comb begin
    hit[0] = !grp_i && (fn_i == FN_CLZ);
    hit[1] = !grp_i && (fn_i == FN_CLO);
    hit[2] =  grp_i && (fn_i == FN_EXT);
    hit[3] =  grp_i && (fn_i == FN_INS);
    hit[4] =  grp_i && (fn_i == FN_SHUF) && (sel_i == SH_WSBH);
    hit[5] =  grp_i && (fn_i == FN_SHUF) && (sel_i == SH_SEB);
    hit[6] =  grp_i && (fn_i == FN_SHUF) && (sel_i == SH_SEH);
  end

  always_comb begin
    op_o = OP_NONE;
    unique case (1'b1)
      hit[0]:  op_o = OP_CLZ;
      hit[1]:  op_o = OP_CLO;
      hit[2]:  op_o = OP_EXT;
      hit[3]:  op_o = OP_INS;
      hit[4]:  op_o = OP_WSBH;
      hit[5]:  op_o = OP_SEB;
      hit[6]:  op_o = OP_SEH;
      default: op_o = OP_NONE;
    endcase
  end

  // R10
  always_comb begin
    dec_onehot_chk: assert ($onehot0(hit))
      else $error("encodings overlap: %b", hit);
  end

endmodule

// File: rtl/bmu_lead_count.sv
module bmu_lead_count #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] vec_i,
  input  logic          ones_i,
  output logic [DW-1:0] cnt_o
);

  localparam int CW = $clog2(DW + 1);

  logic [DW-1:0] scan;
  logic [CW-1:0] cnt;

  function automatic logic [CW-1:0] lead_zeros(input logic [DW-1:0] v);
    logic [CW-1:0] n;
    logic          seen;
    n    = '0;
    seen = 1'b0;
    for (int i = DW - 1; i >= 0; i--) begin
      if (v[i]) seen = 1'b1;
      if (!seen) n = n + 1'b1;
    end
    return n;
  endfunction

  assign scan  = ones_i ? ~vec_i : vec_i;
  assign cnt   = lead_zeros(scan);
  assign cnt_o = DW'(cnt);

  // R1
  always_comb begin
    if (int'(cnt) < DW) begin
      lead_stop_chk: assert ((scan >> (DW - 1 - int'(cnt))) == DW'(1))
        else $error("leading count %0d does not stop at first set bit", cnt);
    end
  end

  // R2
  always_comb begin
    lead_full_chk: assert ((int'(cnt) == DW) == (scan == '0))
      else $error("leading count %0d inconsistent with empty scan", cnt);
  end

endmodule

// File: rtl/bmu_field.sv
module bmu_field #(
  parameter int DW = 32
) (
  input  logic [DW-1:0]         rs_i,
  input  logic [DW-1:0]         rt_i,
  input  logic [$clog2(DW)-1:0] hi_i,
  input  logic [$clog2(DW)-1:0] lo_i,
  input  logic                  ins_i,
  output logic [DW-1:0]         res_o,
  output logic                  bad_o
);

  localparam int FW = $clog2(DW);

  function automatic logic [DW-1:0] low_mask(input logic [FW:0] n);
    logic [DW:0] t;
    t = ({{DW{1'b0}}, 1'b1} << n) - 1'b1;
    return t[DW-1:0];
  endfunction

  logic [FW:0]   ext_top;
  logic [FW:0]   ext_len;
  logic          ext_bad;
  logic [DW-1:0] ext_val;

  logic [FW:0]   ins_len;
  logic          ins_bad;
  logic [DW-1:0] ins_msk;
  logic [DW-1:0] ins_val;

  always_comb begin
    ext_top = {1'b0, hi_i} + {1'b0, lo_i};
    ext_len = {1'b0, hi_i} + 1'b1;
    ext_bad = ext_top > (FW + 1)'(DW - 1);
    ext_val = (rs_i >> lo_i) & low_mask(ext_len);
  end

  always_comb begin
    ins_bad = lo_i > hi_i;
    ins_len = {1'b0, hi_i} - {1'b0, lo_i} + 1'b1;
    ins_msk = low_mask(ins_len) << lo_i;
    ins_val = (rt_i & ~ins_msk) | ((rs_i << lo_i) & ins_msk);
  end

  assign bad_o = ins_i ? ins_bad : ext_bad;
  assign res_o = ins_i ? ins_val : ext_val;

  // R3
  always_comb begin
    if (!ins_i && !ext_bad && hi_i != FW'(DW - 1)) begin
      ext_zext_chk: assert ((res_o >> ext_len) == '0)
        else $error("extract leaves bits above field size %0d", ext_len);
    end
  end

  // R5
  always_comb begin
    if (ins_i && !ins_bad) begin
      ins_field_chk: assert ((((res_o >> lo_i) ^ rs_i) & low_mask(ins_len)) == '0)
        else $error("insert field does not carry rs low bits");
    end
  end

endmodule

// File: rtl/bmu_shuffle.sv
module bmu_shuffle
  import bmu_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] rt_i,
  input  bmu_op_e       op_i,
  output logic [DW-1:0] res_o
);

  localparam int NHALF = DW / 16;

  logic [DW-1:0] swp;
  logic [DW-1:0] sxb;
  logic [DW-1:0] sxh;

  for (genvar h = 0; h < NHALF; h++) begin : g_half
    assign swp[16*h +: 16] = {rt_i[16*h +: 8], rt_i[16*h + 8 +: 8]};
  end

  assign sxb = {{(DW - 8){rt_i[7]}}, rt_i[7:0]};
  assign sxh = {{(DW - 16){rt_i[15]}}, rt_i[15:0]};

  always_comb begin
    case (op_i)
      OP_SEB:  res_o = sxb;
      OP_SEH:  res_o = sxh;
      default: res_o = swp;
    endcase
  end

  // R8
  always_comb begin
    if (op_i == OP_SEB) begin
      seb_sign_chk: assert ($countones(res_o[DW-1:7]) == 0 ||
                            $countones(res_o[DW-1:7]) == DW - 7)
        else $error("byte sign extension not uniform");
    end
  end

  // R9
  always_comb begin
    if (op_i == OP_SEH) begin
      seh_sign_chk: assert ($countones(res_o[DW-1:15]) == 0 ||
                            $countones(res_o[DW-1:15]) == DW - 15)
        else $error("halfword sign extension not uniform");
    end
  end

endmodule

// File: rtl/bmu_core.sv
module bmu_core
  import bmu_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic                  grp_i,
  input  logic [5:0]            fn_i,
  input  logic [$clog2(DW)-1:0] fhi_i,
  input  logic [$clog2(DW)-1:0] flo_i,
  input  logic [DW-1:0]         rs_i,
  input  logic [DW-1:0]         rt_i,
  output logic [DW-1:0]         res_o,
  output logic                  bad_o
);

  bmu_op_e       op;
  logic [DW-1:0] cnt_res;
  logic [DW-1:0] fld_res;
  logic          fld_bad;
  logic [DW-1:0] shf_res;
  logic          enc_bad;
  logic          geo_bad;

  bmu_decode u_dec (
    .grp_i (grp_i),
    .fn_i  (fn_i),
    .sel_i (flo_i),
    .op_o  (op)
  );

  bmu_lead_count #(.DW(DW)) u_cnt (
    .vec_i  (rs_i),
    .ones_i (op == OP_CLO),
    .cnt_o  (cnt_res)
  );

  bmu_field #(.DW(DW)) u_fld (
    .rs_i  (rs_i),
    .rt_i  (rt_i),
    .hi_i  (fhi_i),
    .lo_i  (flo_i),
    .ins_i (op == OP_INS),
    .res_o (fld_res),
    .bad_o (fld_bad)
  );

  bmu_shuffle #(.DW(DW)) u_shf (
    .rt_i  (rt_i),
    .op_i  (op),
    .res_o (shf_res)
  );

  assign enc_bad = (op == OP_NONE);
  assign geo_bad = (op == OP_EXT || op == OP_INS) && fld_bad;
  assign bad_o   = enc_bad || geo_bad;

  always_comb begin
    res_o = '0;
    if (!bad_o) begin
      case (op)
        OP_CLZ, OP_CLO:         res_o = cnt_res;
        OP_EXT, OP_INS:         res_o = fld_res;
        OP_WSBH, OP_SEB, OP_SEH: res_o = shf_res;
        default:                res_o = '0;
      endcase
    end
  end

  // R4 R6 R10
  always_comb begin
    if (enc_bad || fld_bad && (op == OP_EXT || op == OP_INS)) begin
      bad_zero_chk: assert (res_o == '0 && bad_o)
        else $error("invalid operation produced nonzero result %h", res_o);
    end
  end

  // R7
  always_comb begin
    if (op == OP_WSBH) begin
      wsbh_perm_chk: assert ($countones(res_o) == $countones(rt_i))
        else $error("byte swap changed population count");
    end
  end

endmodule

// File: tb/sim_bmu_core.sv
module sim_bmu_core;

  logic        clk;
  logic        rst;
  logic        grp;
  logic [5:0]  fn;
  logic [4:0]  fhi;
  logic [4:0]  flo;
  logic [31:0] rs;
  logic [31:0] rt;
  logic [31:0] res;
  logic        bad;

  int checks = 0;
  int errors = 0;

  bmu_core u0 (
    .grp_i (grp),
    .fn_i  (fn),
    .fhi_i (fhi),
    .flo_i (flo),
    .rs_i  (rs),
    .rt_i  (rt),
    .res_o (res),
    .bad_o (bad)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic logic [31:0] m_lead(input logic [31:0] v, input bit ones);
    int n = 0;
    while (n < 32 && v[31 - n] == ones) n++;
    return 32'(n);
  endfunction

  // expected {bad, result}; tag names the requirement
  function automatic logic [32:0] m_eval(input logic g, input logic [5:0] f,
                                         input logic [4:0] h, input logic [4:0] l,
                                         input logic [31:0] a, input logic [31:0] b,
                                         output string tag);
    logic [31:0] r;
    r = '0;
    tag = "R10";
    if (!g && f == 6'h20) begin tag = "R1"; return {1'b0, m_lead(a, 1'b0)}; end
    if (!g && f == 6'h21) begin tag = "R2"; return {1'b0, m_lead(a, 1'b1)}; end
    if (g && f == 6'h00) begin
      if (int'(h) + int'(l) > 31) begin tag = "R4"; return {1'b1, 32'h0}; end
      tag = "R3";
      for (int i = 0; i <= int'(h); i++) r[i] = a[int'(l) + i];
      return {1'b0, r};
    end
    if (g && f == 6'h04) begin
      if (l > h) begin tag = "R6"; return {1'b1, 32'h0}; end
      tag = "R5";
      r = b;
      for (int i = int'(l); i <= int'(h); i++) r[i] = a[i - int'(l)];
      return {1'b0, r};
    end
    if (g && f == 6'h20 && l == 5'h02) begin
      tag = "R7";
      return {1'b0, b[23:16], b[31:24], b[7:0], b[15:8]};
    end
    if (g && f == 6'h20 && l == 5'h10) begin
      tag = "R8";
      return {1'b0, 32'($signed(b[7:0]))};
    end
    if (g && f == 6'h20 && l == 5'h18) begin
      tag = "R9";
      return {1'b0, 32'($signed(b[15:0]))};
    end
    return {1'b1, 32'h0};
  endfunction

  task automatic apply(input logic g, input logic [5:0] f, input logic [4:0] h,
                       input logic [4:0] l, input logic [31:0] a, input logic [31:0] b);
    logic [32:0] e;
    string tag;
    @(negedge clk);
    grp = g; fn = f; fhi = h; flo = l; rs = a; rt = b;
    #2;
    e = m_eval(g, f, h, l, a, b, tag);
    checks++;
    if ({bad, res} !== e) begin
      errors++;
      $display("FAIL %s: g=%0d fn=%h hi=%0d lo=%0d rs=%h rt=%h actual bad=%0d res=%h expected bad=%0d res=%h",
               tag, g, f, h, l, a, b, bad, res, e[32], e[31:0]);
    end
  endtask

  initial begin
    void'($urandom(32'd7321));
    rst = 1'b1;
    grp = 1'b0; fn = '0; fhi = '0; flo = '0; rs = '0; rt = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;

    // state after reset with zero inputs: unrecognised encoding (R10)
    apply(1'b0, 6'h00, 5'd0, 5'd0, 32'h0, 32'h0);

    // R1 directed
    apply(1'b0, 6'h20, 5'd0, 5'd0, 32'h0000_0000, 32'h0);
    apply(1'b0, 6'h20, 5'd0, 5'd0, 32'h0000_0001, 32'h0);
    apply(1'b0, 6'h20, 5'd0, 5'd0, 32'h8000_0000, 32'h0);
    // R2 directed
    apply(1'b0, 6'h21, 5'd0, 5'd0, 32'hFFFF_FFFF, 32'h0);
    apply(1'b0, 6'h21, 5'd0, 5'd0, 32'h7FFF_FFFF, 32'h0);
    apply(1'b0, 6'h21, 5'd0, 5'd0, 32'hFFF0_0000, 32'h0);
    // R3 / R4 directed
    apply(1'b1, 6'h00, 5'd31, 5'd0,  32'hDEAD_BEEF, 32'h0);
    apply(1'b1, 6'h00, 5'd0,  5'd31, 32'h8000_0000, 32'h0);
    apply(1'b1, 6'h00, 5'd7,  5'd8,  32'h1234_5678, 32'h0);
    apply(1'b1, 6'h00, 5'd1,  5'd31, 32'hFFFF_FFFF, 32'h0);
    apply(1'b1, 6'h00, 5'd31, 5'd1,  32'hFFFF_FFFF, 32'h0);
    // R5 / R6 directed
    apply(1'b1, 6'h04, 5'd9,  5'd9,  32'h0000_0001, 32'h0000_0000);
    apply(1'b1, 6'h04, 5'd31, 5'd0,  32'hA5A5_A5A5, 32'h5A5A_5A5A);
    apply(1'b1, 6'h04, 5'd15, 5'd8,  32'h0000_00CC, 32'hFFFF_FFFF);
    apply(1'b1, 6'h04, 5'd3,  5'd4,  32'hFFFF_FFFF, 32'h1234_5678);
    // R7 / R8 / R9 directed
    apply(1'b1, 6'h20, 5'd0, 5'h02, 32'h0, 32'h1122_3344);
    apply(1'b1, 6'h20, 5'd0, 5'h10, 32'h0, 32'h1234_5680);
    apply(1'b1, 6'h20, 5'd0, 5'h10, 32'h0, 32'hFFFF_FF7F);
    apply(1'b1, 6'h20, 5'd0, 5'h18, 32'h0, 32'h0000_7FFF);
    apply(1'b1, 6'h20, 5'd0, 5'h18, 32'h0, 32'h1234_8001);
    // R10 directed: shuffle code with an unused selector, wrong group
    apply(1'b1, 6'h20, 5'd0, 5'h03, 32'h0, 32'hFFFF_FFFF);
    apply(1'b1, 6'h21, 5'd0, 5'd0,  32'hFFFF_FFFF, 32'h0);
    apply(1'b0, 6'h04, 5'd5, 5'd1,  32'hFFFF_FFFF, 32'h0);
    apply(1'b1, 6'h3F, 5'd5, 5'd1,  32'hFFFF_FFFF, 32'h0);

    // constrained random mix
    for (int it = 0; it < 3000; it++) begin
      logic        g;
      logic [5:0]  f;
      logic [4:0]  h;
      logic [4:0]  l;
      logic [31:0] a;
      logic [31:0] b;
      int          k;
      k = int'($urandom_range(0, 8));
      h = 5'($urandom);
      l = 5'($urandom);
      a = $urandom;
      b = $urandom;
      if ($urandom_range(0, 3) == 0) a = a >> $urandom_range(0, 31);
      if ($urandom_range(0, 5) == 0) a = ~(~a >> $urandom_range(0, 31));
      case (k)
        0: begin g = 1'b0; f = 6'h20; end
        1: begin g = 1'b0; f = 6'h21; end
        2: begin g = 1'b1; f = 6'h00; end
        3: begin g = 1'b1; f = 6'h04; end
        4: begin g = 1'b1; f = 6'h20; l = 5'h02; end
        5: begin g = 1'b1; f = 6'h20; l = 5'h10; end
        6: begin g = 1'b1; f = 6'h20; l = 5'h18; end
        7: begin g = 1'b1; f = 6'h20; end
        default: begin g = 1'($urandom); f = 6'($urandom); end
      endcase
      apply(g, f, h, l, a, b);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule